// File: doc/BRIEF.md
# SD Command Line Engine

This block runs a single SD/eMMC command on the CMD line. Software first sets up the command descriptor: the command index and the response flags in a 32-bit config word, and the response-timeout and inter-command-gap exponents. It then writes the 32-bit argument. That argument write is what starts the command. The engine builds the 48-bit command frame and computes its CRC7. It shifts the frame out MSB first, one bit per card-clock tick, and drives the output enable only while the frame is on the line.

When a response is expected, the engine listens on CMD after the end bit and watches for a start bit within the programmed timeout. It captures a 48-bit or a 136-bit response, checks the CRC7 unless told to skip it, and places the payload in four 32-bit response words. For commands with busy signalling it then waits until data line 0 goes high. Each command ends with a one-cycle done pulse. Timeout and CRC-error pulses, when they occur, come in the same cycle as done. A quiet gap of programmable length always follows before the engine accepts the next argument write.

All line timing advances on `clk_en`, a one-cycle-wide tick in the `clk` domain that marks each card-clock bit period.

Top module: `sd_cmd_engine`

## Requirements
- R1: After reset, `busy`, `cmd_oe`, `done`, `timeout_evt` and `crc_err_evt` are 0, `cmd_out` is 1 and all four response words are 0. A write to `arg_we` while `busy` is 0 starts a command, and `busy` goes to 1 in the next cycle.
- R2: The frame on `cmd_out` is 48 bits, sent MSB first, one bit per `clk_en` tick: start 0, transmission 1, index `cfg_word[29:24]`, the argument, CRC7 (x^7+x^3+1) over the first 40 bits, and end 1. `cmd_oe` is 1 exactly while the frame is driven.
- R3: With `cfg_word[16]` set (no response), the command completes on the tick that ends the end bit, and done is visible in the next cycle with no ticks spent waiting.
- R4: The response wait starts after the end bit. If 2^`rsp_tmo_log2` consecutive ticks sample CMD high, `timeout_evt` and `done` pulse together and the response words keep their old values. A start bit (0) on the last allowed tick is still accepted.
- R5: A 48-bit response (`cfg_word[21]` clear) puts response bits 39:8 in `resp0` and clears `resp1`..`resp3`.
- R6: A 136-bit response (`cfg_word[21]` set) puts response bits 127:0 in the four words, with `resp3` holding bits 127:96 and `resp0` holding bits 31:0.
- R7: The received CRC7 is checked over bits 47:8 of a short response and over bits 127:8 of a long one, against bits 7:1. On a mismatch, `crc_err_evt` pulses with `done`.
- R8: With `cfg_word[20]` set, a CRC mismatch raises no `crc_err_evt`, and the response is still stored.
- R9: With `cfg_word[10]` set (busy after response), `done` is held off until `dat0_in` samples high on a tick.
- R10: After `done`, `busy` stays 1 for exactly 2^`cmd_gap_log2` ticks with `cmd_oe` low. An argument write while `busy` is 1 is ignored.
- R11: `done`, `timeout_evt` and `crc_err_evt` are single-cycle pulses, and the two error pulses never occur without `done` or together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Card-clock bit tick |
| cfg_word | input | 32 | Descriptor config: index 29:24, long 21, skip CRC 20, no response 16, busy-after-response 10 |
| arg_wdata | input | 32 | Command argument |
| arg_we | input | 1 | Argument write strobe, launches the command |
| rsp_tmo_log2 | input | 4 | Response timeout, log2 of ticks |
| cmd_gap_log2 | input | 4 | Inter-command gap, log2 of ticks |
| cmd_in | input | 1 | CMD line input |
| dat0_in | input | 1 | Data line 0 input (busy sense) |
| cmd_out | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD line drive enable |
| busy | output | 1 | Command or gap in progress |
| resp0 | output | 32 | Response word 0 (short response, or bits 31:0 of a long one) |
| resp1 | output | 32 | Response word 1 |
| resp2 | output | 32 | Response word 2 |
| resp3 | output | 32 | Response word 3 (most significant) |
| done | output | 1 | Command completion pulse |
| timeout_evt | output | 1 | Response timeout pulse |
| crc_err_evt | output | 1 | Response CRC mismatch pulse |

## Verification
The assertions check the following on every cycle:
- the line drive only rises after an accepted argument write, and starts with a 0 start bit;
- `cmd_oe` never appears outside `busy`;
- the event pulses are single-cycle, mutually exclusive and tied to `done`;
- every completion is followed by a quiet gap.

Only the bench scenarios can show the rest:
- the frame contents and the CRC7 value on the line;
- where the response words land for short and long responses;
- CRC mismatch detection and its suppression;
- the exact timeout boundary, including a start bit on the last allowed tick;
- the hold-off on data line 0;
- the exact gap length.

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine #(
  parameter int TMR_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clk_en,
  input  logic [31:0] cfg_word,
  input  logic [31:0] arg_wdata,
  input  logic        arg_we,
  input  logic [3:0]  rsp_tmo_log2,
  input  logic [3:0]  cmd_gap_log2,
  input  logic        cmd_in,
  input  logic        dat0_in,
  output logic        cmd_out,
  output logic        cmd_oe,
  output logic        busy,
  output logic [31:0] resp0,
  output logic [31:0] resp1,
  output logic [31:0] resp2,
  output logic [31:0] resp3,
  output logic        done,
  output logic        timeout_evt,
  output logic        crc_err_evt
);
  localparam int FRAME_BITS = 48;
  localparam int LONG_BITS  = 136;
  localparam int CAP_BITS   = 128;
  localparam logic [7:0] FRAME_LAST = 8'(FRAME_BITS - 1);
  localparam logic [7:0] LONG_LAST  = 8'(LONG_BITS - 1);

  typedef enum logic [2:0] {S_IDLE, S_SEND, S_WAIT, S_RECV, S_FIN, S_BUSY, S_GAP} state_t;

  state_t               state;
  logic [FRAME_BITS-1:0] tx_sh;
  logic [CAP_BITS-1:0]   rx_sh;
  logic [7:0]            cnt;
  logic [TMR_W-1:0]      tmr;
  logic [6:0]            crc_rx;
  logic [3:0]            tmo_q, gap_q;
  logic                  long_q, nocrc_q, noresp_q, r1b_q, crc_bad;

  function automatic logic [6:0] frame_crc(input logic [39:0] d);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = 39; i >= 0; i--) begin
      fb = c[6] ^ d[i];
      c  = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  logic [39:0]      frame_head;
  logic [TMR_W-1:0] tmo_lim, gap_lim;
  logic [7:0]       rx_last, rx_pos;
  logic             in_win, crc_mis;
  logic [6:0]       crc_step;
  logic             unused_cfg;

  assign frame_head = {2'b01, cfg_word[29:24], arg_wdata};
  assign tmo_lim    = (TMR_W'(1) << tmo_q) - TMR_W'(1);
  assign gap_lim    = (TMR_W'(1) << gap_q) - TMR_W'(1);
  assign rx_last    = long_q ? LONG_LAST : FRAME_LAST;
  assign rx_pos     = rx_last - cnt;
  assign in_win     = (rx_pos >= 8'd8) && (!long_q || rx_pos <= 8'd127);
  assign crc_step   = {crc_rx[5:0], 1'b0} ^ ((crc_rx[6] ^ cmd_in) ? 7'h09 : 7'h00);
  assign crc_mis    = !nocrc_q && (crc_rx != rx_sh[7:1]);
  assign unused_cfg = ^{cfg_word[31:30], cfg_word[23:22], cfg_word[19:17],
                        cfg_word[15:11], cfg_word[9:0]};

  assign cmd_oe  = (state == S_SEND);
  assign cmd_out = cmd_oe ? tx_sh[FRAME_BITS-1] : 1'b1;
  assign busy    = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      tx_sh       <= '1;
      rx_sh       <= '0;
      cnt         <= '0;
      tmr         <= '0;
      crc_rx      <= '0;
      tmo_q       <= '0;
      gap_q       <= '0;
      long_q      <= 1'b0;
      nocrc_q     <= 1'b0;
      noresp_q    <= 1'b0;
      r1b_q       <= 1'b0;
      crc_bad     <= 1'b0;
      resp0       <= '0;
      resp1       <= '0;
      resp2       <= '0;
      resp3       <= '0;
      done        <= 1'b0;
      timeout_evt <= 1'b0;
      crc_err_evt <= 1'b0;
    end else begin
      done        <= 1'b0;
      timeout_evt <= 1'b0;
      crc_err_evt <= 1'b0;
      case (state)
        S_IDLE: if (arg_we) begin
          tx_sh    <= {frame_head, frame_crc(frame_head), 1'b1};
          long_q   <= cfg_word[21];
          nocrc_q  <= cfg_word[20];
          noresp_q <= cfg_word[16];
          r1b_q    <= cfg_word[10];
          tmo_q    <= rsp_tmo_log2;
          gap_q    <= cmd_gap_log2;
          crc_bad  <= 1'b0;
          cnt      <= '0;
          state    <= S_SEND;
        end
        S_SEND: if (clk_en) begin
          tx_sh <= {tx_sh[FRAME_BITS-2:0], 1'b1};
          if (cnt == FRAME_LAST) begin
            cnt <= '0;
            tmr <= '0;
            if (!noresp_q)  state <= S_WAIT;
            else if (r1b_q) state <= S_BUSY;
            else begin
              state <= S_GAP;
              done  <= 1'b1;
            end
          end else begin
            cnt <= cnt + 8'd1;
          end
        end
        S_WAIT: if (clk_en) begin
          if (!cmd_in) begin
            rx_sh  <= '0;
            crc_rx <= '0;
            cnt    <= 8'd1;
            state  <= S_RECV;
          end else if (tmr == tmo_lim) begin
            tmr         <= '0;
            state       <= S_GAP;
            done        <= 1'b1;
            timeout_evt <= 1'b1;
          end else begin
            tmr <= tmr + TMR_W'(1);
          end
        end
        S_RECV: if (clk_en) begin
          rx_sh <= {rx_sh[CAP_BITS-2:0], cmd_in};
          if (in_win) crc_rx <= crc_step;
          if (cnt == rx_last) state <= S_FIN;
          else                cnt   <= cnt + 8'd1;
        end
        S_FIN: begin
          if (long_q) begin
            resp3 <= rx_sh[127:96];
            resp2 <= rx_sh[95:64];
            resp1 <= rx_sh[63:32];
            resp0 <= rx_sh[31:0];
          end else begin
            resp3 <= '0;
            resp2 <= '0;
            resp1 <= '0;
            resp0 <= rx_sh[39:8];
          end
          tmr <= '0;
          if (r1b_q) begin
            crc_bad <= crc_mis;
            state   <= S_BUSY;
          end else begin
            state       <= S_GAP;
            done        <= 1'b1;
            crc_err_evt <= crc_mis;
          end
        end
        S_BUSY: if (clk_en && dat0_in) begin
          tmr         <= '0;
          state       <= S_GAP;
          done        <= 1'b1;
          crc_err_evt <= crc_bad;
        end
        S_GAP: if (clk_en) begin
          if (tmr == gap_lim) state <= S_IDLE;
          else                tmr   <= tmr + TMR_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_cmd_engine_chk.sv
module sd_cmd_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic arg_we,
  input logic busy,
  input logic cmd_oe,
  input logic cmd_out,
  input logic done,
  input logic timeout_evt,
  input logic crc_err_evt
);
  assert_launch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_oe) |-> ($past(arg_we) && !$past(busy)));

  assert_start_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_oe) |-> !cmd_out);

  assert_oe_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> busy);

  assert_tmo_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |-> done);

  assert_crc_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err_evt |-> done);

  assert_evt_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(timeout_evt && crc_err_evt));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_gap_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (busy && !cmd_oe));
endmodule

bind sd_cmd_engine sd_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .arg_we(arg_we), .busy(busy), .cmd_oe(cmd_oe),
  .cmd_out(cmd_out), .done(done), .timeout_evt(timeout_evt), .crc_err_evt(crc_err_evt)
);

// File: tb/sd_cmd_engine_tb.sv
module sd_cmd_engine_tb;
  logic clk = 1'b0, rst_n = 1'b0, clk_en = 1'b0;
  logic [31:0] cfg_word = '0, arg_wdata = '0;
  logic arg_we = 1'b0, cmd_in = 1'b1, dat0_in = 1'b1;
  logic [3:0] rsp_tmo_log2 = 4'd8, cmd_gap_log2 = 4'd2;
  logic cmd_out, cmd_oe, busy, done, timeout_evt, crc_err_evt;
  logic [31:0] resp0, resp1, resp2, resp3;
  logic [1:0] cc = '0;

  int vectors = 0, errors = 0;
  logic [130:0] exp_q[$];
  string        tag_q[$];
  logic [127:0] last_r = '0;

  always #10 clk = ~clk;
  always @(posedge clk) begin
    cc     <= cc + 2'd1;
    clk_en <= (cc == 2'd2);
  end

  sd_cmd_engine u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_crc(input logic [119:0] m, input int n);
    logic [7:0] r = '0;
    for (int i = n + 6; i >= 0; i--) begin
      r = {r[6:0], (i >= 7) ? m[i-7] : 1'b0};
      if (r[7]) r = r ^ 8'h89;
    end
    return r[6:0];
  endfunction

  function automatic logic [47:0] ref_frame(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] h = {2'b01, idx, arg};
    return {h, ref_crc({80'b0, h}, 40), 1'b1};
  endfunction

  function automatic logic [47:0] short_rsp(input logic [5:0] idx, input logic [31:0] st, input bit bad);
    logic [39:0] h = {2'b00, idx, st};
    return {h, ref_crc({80'b0, h}, 40) ^ (bad ? 7'h01 : 7'h00), 1'b1};
  endfunction

  function automatic logic [135:0] long_rsp(input logic [119:0] body, input bit bad);
    return {8'h3F, body, ref_crc(body, 120) ^ (bad ? 7'h40 : 7'h00), 1'b1};
  endfunction

  function automatic logic [31:0] mk_cfg(input logic [5:0] idx, input bit noresp, input bit lng,
                                         input bit nocrc, input bit r1b);
    return (32'(idx) << 24) | (32'(lng) << 21) | (32'(nocrc) << 20) | (32'(noresp) << 16) | (32'(r1b) << 10);
  endfunction

  // scoreboard monitor: compares every completion against the queued expectation
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) chk(1'b0, "R11 unexpected done", 128'(done), 128'd0);
      else begin
        logic [130:0] it;
        string tg;
        it = exp_q.pop_front();
        tg = tag_q.pop_front();
        chk(timeout_evt == it[129], {tg, " timeout_evt"}, 128'(timeout_evt), 128'(it[129]));
        chk(crc_err_evt == it[128], {tg, " crc_err_evt"}, 128'(crc_err_evt), 128'(it[128]));
        if (it[130])
          chk({resp3, resp2, resp1, resp0} == it[127:0], {tg, " response words"},
              {resp3, resp2, resp1, resp0}, it[127:0]);
      end
    end
  end

  task automatic wait_tick();
    do @(negedge clk); while (clk_en !== 1'b1);
  endtask

  task automatic push(input string tg, input bit cr, input bit tm, input bit cb, input logic [127:0] r);
    exp_q.push_back({cr, tm, cb, r});
    tag_q.push_back(tg);
  endtask

  task automatic launch(input logic [31:0] cfg, input logic [31:0] arg);
    @(negedge clk);
    while (busy) @(negedge clk);
    cfg_word = cfg; arg_wdata = arg; arg_we = 1'b1;
    @(negedge clk);
    arg_we = 1'b0;
  endtask

  task automatic get_frame(input string tg, input logic [47:0] exp);
    logic [47:0] f = '0;
    bit oe_ok = 1'b1;
    for (int i = 0; i < 48; i++) begin
      wait_tick();
      oe_ok &= cmd_oe;
      f = {f[46:0], cmd_out};
    end
    chk(f == exp, {tg, " frame"}, 128'(f), 128'(exp));
    chk(oe_ok, {tg, " cmd_oe over frame"}, 128'(oe_ok), 128'd1);
  endtask

  task automatic send_rsp(input logic [135:0] bits, input int len, input int dly);
    for (int i = 0; i < dly; i++) begin wait_tick(); cmd_in = 1'b1; end
    for (int i = len - 1; i >= 0; i--) begin wait_tick(); cmd_in = bits[i]; end
    @(negedge clk);
    cmd_in = 1'b1;
  endtask

  task automatic wait_done(output int ticks);
    ticks = 0;
    @(negedge clk);
    while (!done) begin
      if (clk_en) ticks++;
      @(negedge clk);
    end
  endtask

  initial begin
    int t;
    logic [47:0] sr;
    logic [135:0] lr;
    logic [119:0] body;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !cmd_oe && cmd_out && !done && !timeout_evt && !crc_err_evt, "R1 reset outputs",
        {122'd0, busy, cmd_oe, cmd_out, done, timeout_evt, crc_err_evt}, 128'h8);
    chk({resp3, resp2, resp1, resp0} == '0, "R1 reset responses", {resp3, resp2, resp1, resp0}, '0);
    rst_n = 1'b1;

    // R2/R3 no-response command, known frame value
    launch(mk_cfg(6'd0, 1, 0, 0, 0), 32'h0);
    @(negedge clk);
    chk(busy, "R1 busy after launch", 128'(busy), 128'd1);
    push("R3 no response", 1'b0, 1'b0, 1'b0, '0);
    get_frame("R2 idx0", 48'h40_0000_0000_95);
    wait_done(t);
    chk(t == 0, "R3 ticks to done", 128'(t), 128'd0);

    // R2/R5 short response
    launch(mk_cfg(6'd8, 0, 0, 0, 0), 32'h1AA);
    sr = short_rsp(6'd8, 32'h0000_01AA, 0);
    last_r = {96'd0, 32'h0000_01AA};
    push("R5 short rsp", 1'b1, 1'b0, 1'b0, last_r);
    get_frame("R2 idx8", 48'h48_0000_01AA_87);
    send_rsp({88'd0, sr}, 48, 3);
    wait_done(t);

    // R7 corrupted short CRC
    launch(mk_cfg(6'd17, 0, 0, 0, 0), 32'hDEAD_BEEF);
    sr = short_rsp(6'd17, 32'h1234_5678, 1);
    last_r = {96'd0, 32'h1234_5678};
    push("R7 short crc bad", 1'b1, 1'b0, 1'b1, last_r);
    get_frame("R2 idx17", ref_frame(6'd17, 32'hDEAD_BEEF));
    send_rsp({88'd0, sr}, 48, 1);
    wait_done(t);

    // R8 same mismatch, CRC check skipped
    launch(mk_cfg(6'd41, 0, 0, 1, 0), 32'h00FF_8000);
    sr = short_rsp(6'h3F, 32'h80FF_8000, 1);
    last_r = {96'd0, 32'h80FF_8000};
    push("R8 skip crc", 1'b1, 1'b0, 1'b0, last_r);
    get_frame("R2 idx41", ref_frame(6'd41, 32'h00FF_8000));
    send_rsp({88'd0, sr}, 48, 0);
    wait_done(t);

    // R6/R7 long response, good then bad
    body = {32'hA5A5_0F0F, 32'h1357_9BDF, 32'h0246_8ACE, 24'hC0FFEE};
    launch(mk_cfg(6'd2, 0, 1, 0, 0), 32'h0);
    lr = long_rsp(body, 0);
    last_r = lr[127:0];
    push("R6 long rsp", 1'b1, 1'b0, 1'b0, last_r);
    get_frame("R2 idx2", ref_frame(6'd2, 32'h0));
    send_rsp(lr, 136, 2);
    wait_done(t);

    launch(mk_cfg(6'd9, 0, 1, 0, 0), 32'h0001_0000);
    lr = long_rsp(~body, 1);
    last_r = lr[127:0];
    push("R7 long crc bad", 1'b1, 1'b0, 1'b1, last_r);
    get_frame("R2 idx9", ref_frame(6'd9, 32'h0001_0000));
    send_rsp(lr, 136, 0);
    wait_done(t);

    // R4 timeout after 8 high ticks, responses untouched
    rsp_tmo_log2 = 4'd3;
    launch(mk_cfg(6'd55, 0, 0, 0, 0), 32'h0);
    push("R4 timeout", 1'b1, 1'b1, 1'b0, last_r);
    get_frame("R2 idx55", ref_frame(6'd55, 32'h0));
    wait_done(t);
    chk(t == 8, "R4 ticks to timeout", 128'(t), 128'd8);

    // R4 start bit on the last allowed tick
    launch(mk_cfg(6'd13, 0, 0, 0, 0), 32'h0BAD_F00D);
    sr = short_rsp(6'd13, 32'h0000_0900, 0);
    last_r = {96'd0, 32'h0000_0900};
    push("R4 last-tick start", 1'b1, 1'b0, 1'b0, last_r);
    get_frame("R2 idx13", ref_frame(6'd13, 32'h0BAD_F00D));
    send_rsp({88'd0, sr}, 48, 7);
    wait_done(t);
    rsp_tmo_log2 = 4'd8;

    // R9 busy hold-off on data line 0
    dat0_in = 1'b0;
    launch(mk_cfg(6'd12, 0, 0, 0, 1), 32'h0);
    sr = short_rsp(6'd12, 32'h0000_0B00, 0);
    last_r = {96'd0, 32'h0000_0B00};
    push("R9 busy release", 1'b1, 1'b0, 1'b0, last_r);
    get_frame("R2 idx12", ref_frame(6'd12, 32'h0));
    send_rsp({88'd0, sr}, 48, 0);
    begin
      bit early = 1'b0;
      for (int i = 0; i < 48; i++) begin
        @(negedge clk);
        early |= done;
      end
      chk(!early, "R9 done held while dat0 low", 128'(early), 128'd0);
    end
    dat0_in = 1'b1;
    wait_done(t);

    // R10 gap length and ignored launch during gap
    cmd_gap_log2 = 4'd4;
    launch(mk_cfg(6'd7, 1, 0, 0, 0), 32'h0000_0001);
    push("R10 gap cmd", 1'b0, 1'b0, 1'b0, '0);
    get_frame("R2 idx7", ref_frame(6'd7, 32'h0000_0001));
    wait_done(t);
    begin
      int n = 0, cyc = 0;
      bit oe_seen = 1'b0;
      @(negedge clk);
      while (busy) begin
        if (clk_en) n++;
        oe_seen |= cmd_oe;
        cyc++;
        if (cyc == 2) begin cfg_word = mk_cfg(6'd1, 1, 0, 0, 0); arg_we = 1'b1; end
        if (cyc == 3) arg_we = 1'b0;
        @(negedge clk);
      end
      chk(n == 16, "R10 gap ticks", 128'(n), 128'd16);
      chk(!oe_seen, "R10 no drive in gap", 128'(oe_seen), 128'd0);
      repeat (20) @(negedge clk);
      chk(!busy && !cmd_oe, "R10 launch during gap ignored", {126'd0, busy, cmd_oe}, 128'd0);
    end
    cmd_gap_log2 = 4'd2;

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R11 all completions seen", 128'(exp_q.size()), 128'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule